// File: doc/BRIEF.md
# Integer Execution Unit for a Randomised Virtual CPU

This block executes one already-decoded integer or control instruction for a virtual processor that has eight 64-bit general registers. The instruction stream it serves is random, so any bit pattern of its fields is a valid operation. The surrounding core reads the destination and source registers and supplies them. It also supplies a flag that tells whether both operands name the same register, a flag for the one register that gets the extra immediate in the shifted add, the 8-bit modifier field, a 32-bit immediate and a memory operand that has already been fetched. The unit returns the new destination value, a second value for the exchange operation, write enables for both, and a branch decision.

Every operation finishes in one cycle except the multiply by the reciprocal of the immediate. That operation runs a bit-serial divider for 63 cycles, then spends one cycle on the product. While it runs, `busy` is high and new requests are dropped. Instruction fetch, the register file, memory access and branch-target tracking all belong to the surrounding core.

Top module: `ixu_top`

## Requirements
- R1: `op` codes: 0 add-shifted, 1 add-mem, 2 sub-reg, 3 sub-mem, 4 mul-reg, 5 mul-mem, 6 mulhu-reg, 7 mulhu-mem, 8 mulhs-reg, 9 mulhs-mem, 10 mul-recip, 11 negate, 12 xor-reg, 13 xor-mem, 14 rotate-right, 15 rotate-left, 16 swap, 17 branch. A request accepted while `busy` is low produces `out_valid` one cycle later, with one exception: mul-recip with an immediate that is neither zero nor a power of two.
- R2: Add-shifted writes dst + (src << mod[3:2]). When `dst_is_r5` is set, it also adds the sign-extended immediate.
- R3: When `same_reg` is set, sub-reg, mul-reg, xor-reg and both rotates use the sign-extended immediate in place of the source value. The memory forms always use `mem_val`.
- R4: Add, subtract and low multiply results wrap modulo 2^64.
- R5: The mulhu and mulhs operations return bits 127..64 of the unsigned or signed 128-bit product. With `same_reg` set they square the destination value.
- R6: Rotate-right and rotate-left turn the destination by the low 6 bits of the source operand.
- R7: Negate writes the two's complement of the destination. Swap writes the source value to the destination and the destination value to the source. Swap with `same_reg` set writes nothing.
- R8: Mul-recip with an immediate of zero or a power of two completes in one cycle with `wr_dst` low.
- R9: Any other mul-recip immediate gives dst * floor(2^x / imm) mod 2^64. The immediate is read as unsigned and x is the largest value that keeps the quotient below 2^64. `busy` stays high until the result appears, and requests arriving during that time are dropped.
- R10: For the branch, b = mod[7:4] + 8. The unit adds to the destination the sign-extended immediate with bit b forced to 1 and bit b-1 forced to 0, and writes the sum.
- R11: The branch is taken when bits b through b+7 of that sum are all zero.
- R12: `wr_src` is set only by swap, and `branch_taken` only by the branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, ignored while busy |
| op | input | 5 | Operation code |
| dst_val | input | 64 | Destination register value |
| src_val | input | 64 | Source register value |
| same_reg | input | 1 | Destination and source name one register |
| dst_is_r5 | input | 1 | Destination is the register that takes the extra immediate |
| mod | input | 8 | Modifier: [3:2] shift, [7:4] branch condition |
| imm | input | 32 | Immediate |
| mem_val | input | 64 | Loaded memory operand |
| busy | output | 1 | Reciprocal multiply in progress |
| out_valid | output | 1 | Result strobe |
| dst_out | output | 64 | New destination value |
| src_out | output | 64 | New source value (swap) |
| wr_dst | output | 1 | Destination write enable |
| wr_src | output | 1 | Source write enable |
| branch_taken | output | 1 | Branch decision |

## Verification
The bench uses the default build: 64-bit data, 32-bit immediate, an 8-bit branch window at offset 8. With these values the reciprocal quotient and the 128-bit products can be checked against exact wide arithmetic in the bench. The condition values 0 and 15 place the tested window at bits 8..15 and 23..30, which are its lowest and highest positions. The long reciprocal run also leaves time to send a competing request and to show at the outputs that it was dropped.

// File: rtl/ixu_pkg.sv
package ixu_pkg;

    localparam int XLEN      = 64;
    localparam int IMM_BITS  = 32;
    localparam int WIN_BITS  = 8;
    localparam int WIN_BASE  = 8;

    typedef enum logic [4:0] {
        OP_ADD_SHL   = 5'd0,
        OP_ADD_MEM   = 5'd1,
        OP_SUB_REG   = 5'd2,
        OP_SUB_MEM   = 5'd3,
        OP_MUL_REG   = 5'd4,
        OP_MUL_MEM   = 5'd5,
        OP_MULHU_REG = 5'd6,
        OP_MULHU_MEM = 5'd7,
        OP_MULHS_REG = 5'd8,
        OP_MULHS_MEM = 5'd9,
        OP_MUL_RECIP = 5'd10,
        OP_NEG       = 5'd11,
        OP_XOR_REG   = 5'd12,
        OP_XOR_MEM   = 5'd13,
        OP_ROTR      = 5'd14,
        OP_ROTL      = 5'd15,
        OP_SWAP      = 5'd16,
        OP_BRANCH    = 5'd17
    } op_e;

    typedef struct packed {
        logic wr_dst;
        logic wr_src;
        logic taken;
    } ixu_flags_t;

    typedef enum logic [1:0] {
        DV_IDLE = 2'd0,
        DV_RUN  = 2'd1,
        DV_FIN  = 2'd2
    } div_state_e;

endpackage

// File: rtl/ixu_alu.sv
module ixu_alu
    import ixu_pkg::*;
#(
    parameter int DATA_W = XLEN,
    parameter int IMM_W  = IMM_BITS
) (
    input  op_e                op,
    input  logic [DATA_W-1:0]  dst,
    input  logic [DATA_W-1:0]  src,
    input  logic               same,
    input  logic               is_r5,
    input  logic [1:0]         shamt,
    input  logic [IMM_W-1:0]   imm,
    input  logic [DATA_W-1:0]  mem,
    output logic [DATA_W-1:0]  res_dst,
    output logic [DATA_W-1:0]  res_src,
    output ixu_flags_t         flags
);
    localparam int SH_W = $clog2(DATA_W);

    logic [DATA_W-1:0] imm_sx, opnd_r, hi_opnd, add_rs;
    logic [DATA_W-1:0] pu_hi, pu_lo_unused, ps_hi, ps_lo_unused;
    logic [DATA_W-1:0] ror_v, ror_unused, rol_v, rol_unused;
    logic [SH_W-1:0]   rot_n;

    assign imm_sx  = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
    assign opnd_r  = same ? imm_sx : src;
    assign add_rs  = dst + (src << shamt) + (is_r5 ? imm_sx : '0);
    assign hi_opnd = (op == OP_MULHU_MEM || op == OP_MULHS_MEM) ? mem : src;

    assign {pu_hi, pu_lo_unused} = {{DATA_W{1'b0}}, dst} * {{DATA_W{1'b0}}, hi_opnd};
    assign {ps_hi, ps_lo_unused} = {{DATA_W{dst[DATA_W-1]}}, dst}
                                 * {{DATA_W{hi_opnd[DATA_W-1]}}, hi_opnd};

    assign rot_n = opnd_r[SH_W-1:0];
    assign {ror_unused, ror_v} = {dst, dst} >> rot_n;
    assign {rol_v, rol_unused} = {dst, dst} << rot_n;

    always_comb begin
        res_dst      = dst;
        res_src      = src;
        flags.wr_dst = 1'b1;
        flags.wr_src = 1'b0;
        flags.taken  = 1'b0;
        unique case (op)
            OP_ADD_SHL:   res_dst = add_rs;
            OP_ADD_MEM:   res_dst = dst + mem;
            OP_SUB_REG:   res_dst = dst - opnd_r;
            OP_SUB_MEM:   res_dst = dst - mem;
            OP_MUL_REG:   res_dst = dst * opnd_r;
            OP_MUL_MEM:   res_dst = dst * mem;
            OP_MULHU_REG,
            OP_MULHU_MEM: res_dst = pu_hi;
            OP_MULHS_REG,
            OP_MULHS_MEM: res_dst = ps_hi;
            OP_NEG:       res_dst = '0 - dst;
            OP_XOR_REG:   res_dst = dst ^ opnd_r;
            OP_XOR_MEM:   res_dst = dst ^ mem;
            OP_ROTR:      res_dst = ror_v;
            OP_ROTL:      res_dst = rol_v;
            OP_SWAP: begin
                res_dst      = src;
                res_src      = dst;
                flags.wr_dst = !same;
                flags.wr_src = !same;
            end
            default:      flags.wr_dst = 1'b0;
        endcase
    end
endmodule

// File: rtl/ixu_branch.sv
module ixu_branch
    import ixu_pkg::*;
#(
    parameter int DATA_W   = XLEN,
    parameter int IMM_W    = IMM_BITS,
    parameter int COND_W   = 4,
    parameter int JMP_BITS = WIN_BITS,
    parameter int JMP_OFS  = WIN_BASE
) (
    input  logic [DATA_W-1:0] dst,
    input  logic [IMM_W-1:0]  imm,
    input  logic [COND_W-1:0] cond,
    output logic [DATA_W-1:0] new_dst,
    output logic              taken
);
    localparam int B_W = $clog2(DATA_W);

    logic [B_W-1:0]    bpos;
    logic [DATA_W-1:0] cimm, window_v;

    assign bpos = B_W'(cond) + B_W'(JMP_OFS);

    always_comb begin
        cimm           = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
        cimm[bpos]     = 1'b1;
        cimm[bpos - 1] = 1'b0;
    end

    assign new_dst  = dst + cimm;
    assign window_v = (new_dst >> bpos) & {{(DATA_W-JMP_BITS){1'b0}}, {JMP_BITS{1'b1}}};
    assign taken    = (window_v == '0);
endmodule

// File: rtl/ixu_rcp_div.sv
module ixu_rcp_div
    import ixu_pkg::*;
#(
    parameter int DIV_W = IMM_BITS,
    parameter int Q_W   = XLEN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DIV_W-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic [Q_W-1:0]   quot
);
    localparam int CNT_W = $clog2(Q_W);

    div_state_e        state;
    logic [DIV_W-1:0]  d_q, rem_q, r_init;
    logic [DIV_W:0]    pow_v, r2;
    logic              r_init_unused;
    logic [CNT_W-1:0]  cnt;
    int                top_idx;

    always_comb begin
        top_idx = 0;
        for (int i = 0; i < DIV_W; i++) begin
            if (divisor[i]) top_idx = i;
        end
        pow_v = (DIV_W+1)'(1) << (top_idx + 1);
    end

    assign {r_init_unused, r_init} = pow_v - {1'b0, divisor};
    assign r2   = {rem_q, 1'b0};
    assign busy = (state != DV_IDLE);
    assign done = (state == DV_FIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= DV_IDLE;
            d_q   <= '0;
            rem_q <= '0;
            quot  <= '0;
            cnt   <= '0;
        end else begin
            unique case (state)
                DV_IDLE: if (start) begin
                    d_q   <= divisor;
                    rem_q <= r_init;
                    quot  <= Q_W'(1);
                    cnt   <= '0;
                    state <= DV_RUN;
                end
                DV_RUN: begin
                    if (r2 >= {1'b0, d_q}) begin
                        rem_q <= DIV_W'(r2 - {1'b0, d_q});
                        quot  <= {quot[Q_W-2:0], 1'b1};
                    end else begin
                        rem_q <= r2[DIV_W-1:0];
                        quot  <= {quot[Q_W-2:0], 1'b0};
                    end
                    cnt <= cnt + 1'b1;
                    if (cnt == CNT_W'(Q_W-2)) state <= DV_FIN;
                end
                default: state <= DV_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ixu_top.sv
module ixu_top
    import ixu_pkg::*;
#(
    parameter int DATA_W   = XLEN,
    parameter int IMM_W    = IMM_BITS,
    parameter int JMP_BITS = WIN_BITS,
    parameter int JMP_OFS  = WIN_BASE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [4:0]        op,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_val,
    input  logic              same_reg,
    input  logic              dst_is_r5,
    input  logic [7:0]        mod,
    input  logic [IMM_W-1:0]  imm,
    input  logic [DATA_W-1:0] mem_val,
    output logic              busy,
    output logic              out_valid,
    output logic [DATA_W-1:0] dst_out,
    output logic [DATA_W-1:0] src_out,
    output logic              wr_dst,
    output logic              wr_src,
    output logic              branch_taken
);
    op_e               op_q;
    logic              accept, rcp_trivial, rcp_go, div_busy, div_done, br_taken;
    logic              unused_mod_mem;
    logic [DATA_W-1:0] alu_dst, alu_src, br_dst, dst_hold, div_quot, rcp_prod;
    logic [DATA_W-1:0] nx_dst, nx_src;
    ixu_flags_t        alu_flags, nx_flags;

    assign op_q           = op_e'(op);
    assign unused_mod_mem = ^mod[1:0];
    assign accept         = start && !div_busy;
    assign rcp_trivial    = (imm == '0) || ((imm & (imm - 1'b1)) == '0);
    assign rcp_go         = accept && (op_q == OP_MUL_RECIP) && !rcp_trivial;
    assign busy           = div_busy;
    assign rcp_prod       = dst_hold * div_quot;

    ixu_alu #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_alu (
        .op(op_q), .dst(dst_val), .src(src_val), .same(same_reg),
        .is_r5(dst_is_r5), .shamt(mod[3:2]), .imm(imm), .mem(mem_val),
        .res_dst(alu_dst), .res_src(alu_src), .flags(alu_flags)
    );

    ixu_branch #(.DATA_W(DATA_W), .IMM_W(IMM_W), .COND_W(4),
                 .JMP_BITS(JMP_BITS), .JMP_OFS(JMP_OFS)) u_branch (
        .dst(dst_val), .imm(imm), .cond(mod[7:4]),
        .new_dst(br_dst), .taken(br_taken)
    );

    ixu_rcp_div #(.DIV_W(IMM_W), .Q_W(DATA_W)) u_div (
        .clk(clk), .rst(rst), .start(rcp_go), .divisor(imm),
        .busy(div_busy), .done(div_done), .quot(div_quot)
    );

    always_comb begin
        nx_dst   = alu_dst;
        nx_src   = alu_src;
        nx_flags = alu_flags;
        if (op_q == OP_BRANCH) begin
            nx_dst   = br_dst;
            nx_flags = '{wr_dst: 1'b1, wr_src: 1'b0, taken: br_taken};
        end else if (op_q == OP_MUL_RECIP) begin
            nx_dst   = dst_val;
            nx_flags = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            dst_out      <= '0;
            src_out      <= '0;
            wr_dst       <= 1'b0;
            wr_src       <= 1'b0;
            branch_taken <= 1'b0;
            dst_hold     <= '0;
        end else begin
            out_valid <= 1'b0;
            if (rcp_go) begin
                dst_hold <= dst_val;
            end else if (accept) begin
                out_valid    <= 1'b1;
                dst_out      <= nx_dst;
                src_out      <= nx_src;
                wr_dst       <= nx_flags.wr_dst;
                wr_src       <= nx_flags.wr_src;
                branch_taken <= nx_flags.taken;
            end else if (div_done) begin
                out_valid    <= 1'b1;
                dst_out      <= rcp_prod;
                src_out      <= '0;
                wr_dst       <= 1'b1;
                wr_src       <= 1'b0;
                branch_taken <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ixu_chk.sv
module ixu_chk
    import ixu_pkg::*;
#(
    parameter int IMM_W = IMM_BITS
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [4:0]       op,
    input logic             same_reg,
    input logic [IMM_W-1:0] imm,
    input logic             busy,
    input logic             out_valid,
    input logic             wr_dst,
    input logic             wr_src,
    input logic             branch_taken
);
    logic [4:0] last_op;
    logic       take, pow_or_zero, long_rcp;

    assign take        = start && !busy;
    assign pow_or_zero = (imm == '0) || ($countones(imm) == 1);
    assign long_rcp    = (op == 5'd10) && !pow_or_zero;

    always_ff @(posedge clk) begin
        if (rst) last_op <= 5'd0;
        else if (take) last_op <= op;
    end

    AST_QUICK_RESULT: assert property (@(posedge clk) disable iff (rst)
        take && !long_rcp |=> out_valid);                          // R1
    AST_RCP_TRIVIAL: assert property (@(posedge clk) disable iff (rst)
        take && op == 5'd10 && pow_or_zero |=> out_valid && !wr_dst); // R8
    AST_RCP_BUSY: assert property (@(posedge clk) disable iff (rst)
        take && long_rcp |=> busy && !out_valid);                  // R9
    AST_BUSY_NO_RESULT: assert property (@(posedge clk) disable iff (rst)
        busy |-> !out_valid);                                      // R9
    AST_SWAP_SAME: assert property (@(posedge clk) disable iff (rst)
        take && op == 5'd16 && same_reg |=> !wr_dst && !wr_src);    // R7
    AST_SRC_WRITE_SWAP: assert property (@(posedge clk) disable iff (rst)
        out_valid && wr_src |-> last_op == 5'd16);                 // R12
    AST_TAKEN_BRANCH: assert property (@(posedge clk) disable iff (rst)
        out_valid && branch_taken |-> last_op == 5'd17);           // R12
endmodule

bind ixu_top ixu_chk #(.IMM_W(IMM_W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .op(op), .same_reg(same_reg),
    .imm(imm), .busy(busy), .out_valid(out_valid), .wr_dst(wr_dst),
    .wr_src(wr_src), .branch_taken(branch_taken)
);

// File: tb/ixu_top_tb.sv
module ixu_top_tb;
    import ixu_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst, start, same_reg, dst_is_r5;
    logic [4:0]  op;
    logic [63:0] dst_val, src_val, mem_val;
    logic [7:0]  mod;
    logic [31:0] imm;
    logic        busy, out_valid, wr_dst, wr_src, branch_taken;
    logic [63:0] dst_out, src_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ixu_top u_dut (
        .clk(clk), .rst(rst), .start(start), .op(op), .dst_val(dst_val),
        .src_val(src_val), .same_reg(same_reg), .dst_is_r5(dst_is_r5),
        .mod(mod), .imm(imm), .mem_val(mem_val), .busy(busy),
        .out_valid(out_valid), .dst_out(dst_out), .src_out(src_out),
        .wr_dst(wr_dst), .wr_src(wr_src), .branch_taken(branch_taken)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_rcp(input logic [31:0] d);
        logic [127:0] num, q;
        num = 128'd1 << (63 + $clog2(d));
        q   = num / {96'd0, d};
        return q[63:0];
    endfunction

    function automatic void ref_model(
        input op_e o, input logic [63:0] d, s, input logic same, r5,
        input logic [7:0] m, input logic [31:0] im, input logic [63:0] mv,
        output logic [63:0] ed, es, output logic ewd, ews, etk);
        logic [63:0]  sx, rs;
        logic signed [127:0] sp;
        logic [127:0] up;
        int b;
        sx = {{32{im[31]}}, im};
        rs = same ? sx : s;
        ed = d; es = s; ewd = 1'b1; ews = 1'b0; etk = 1'b0;
        case (o)
            OP_ADD_SHL:   ed = d + (s << m[3:2]) + (r5 ? sx : 64'd0);
            OP_ADD_MEM:   ed = d + mv;
            OP_SUB_REG:   ed = d - rs;
            OP_SUB_MEM:   ed = d - mv;
            OP_MUL_REG:   ed = d * rs;
            OP_MUL_MEM:   ed = d * mv;
            OP_MULHU_REG: begin up = {64'd0, d} * {64'd0, s};  ed = up[127:64]; end
            OP_MULHU_MEM: begin up = {64'd0, d} * {64'd0, mv}; ed = up[127:64]; end
            OP_MULHS_REG: begin sp = $signed(d) * $signed(s);  ed = sp[127:64]; end
            OP_MULHS_MEM: begin sp = $signed(d) * $signed(mv); ed = sp[127:64]; end
            OP_NEG:       ed = ~d + 64'd1;
            OP_XOR_REG:   ed = d ^ rs;
            OP_XOR_MEM:   ed = d ^ mv;
            OP_ROTR:      ed = (d >> rs[5:0]) | (d << (7'd64 - {1'b0, rs[5:0]}));
            OP_ROTL:      ed = (d << rs[5:0]) | (d >> (7'd64 - {1'b0, rs[5:0]}));
            OP_SWAP: begin ed = s; es = d; ewd = !same; ews = !same; end
            OP_MUL_RECIP: begin
                if (im == 0 || (im & (im - 1)) == 0) ewd = 1'b0;
                else ed = d * ref_rcp(im);
            end
            OP_BRANCH: begin
                b = int'(m[7:4]) + 8;
                sx[b] = 1'b1; sx[b-1] = 1'b0;
                ed = d + sx;
                etk = (((ed >> b) & 64'hFF) == 64'd0);
            end
            default: ewd = 1'b0;
        endcase
    endfunction

    task automatic run(input string req, input op_e o, input logic [63:0] d, s,
                       input logic same, r5, input logic [7:0] m,
                       input logic [31:0] im, input logic [63:0] mv);
        logic [63:0] ed, es;
        logic ewd, ews, etk, quick;
        int waited;
        ref_model(o, d, s, same, r5, m, im, mv, ed, es, ewd, ews, etk);
        quick = !(o == OP_MUL_RECIP && im != 0 && (im & (im - 1)) != 0);
        @(negedge clk);
        start = 1'b1; op = o; dst_val = d; src_val = s; same_reg = same;
        dst_is_r5 = r5; mod = m; imm = im; mem_val = mv;
        @(negedge clk);
        start = 1'b0;
        if (quick) begin
            check("R1", "one-cycle out_valid", {63'd0, out_valid}, 64'd1);
        end else begin
            check("R9", "busy during recip", {63'd0, busy}, 64'd1);
            waited = 0;
            while (!out_valid && waited < 200) begin
                @(negedge clk);
                waited++;
                if (!out_valid) check("R9", "busy held", {63'd0, busy}, 64'd1);
            end
        end
        check(req, "wr_dst", {63'd0, wr_dst}, {63'd0, ewd});
        if (ewd) check(req, "dst_out", dst_out, ed);
        check("R12", "wr_src", {63'd0, wr_src}, {63'd0, ews});
        if (ews) check(req, "src_out", src_out, es);
        check(req == "R11" ? "R11" : "R12", "branch_taken",
              {63'd0, branch_taken}, {63'd0, etk});
    endtask

    task automatic t_reset;
        check("R1", "reset out_valid", {63'd0, out_valid}, 64'd0);
        check("R9", "reset busy", {63'd0, busy}, 64'd0);
        check("R12", "reset wr_src", {63'd0, wr_src}, 64'd0);
    endtask

    task automatic t_add;
        run("R2", OP_ADD_SHL, 64'h0000_0000_0000_1000, 64'h3, 0, 0, 8'b0000_1100, 32'hDEAD, 0);
        run("R2", OP_ADD_SHL, 64'h10, 64'h1, 0, 1, 8'b0000_0100, 32'hFFFF_FFF0, 0);
        run("R2", OP_ADD_SHL, 64'h7, 64'h7, 1, 0, 8'b0000_1000, 32'h5, 0);
    endtask

    task automatic t_same;
        run("R3", OP_SUB_REG, 64'h100, 64'h100, 1, 0, 0, 32'hFFFF_FFFF, 0);
        run("R3", OP_MUL_REG, 64'h3, 64'h3, 1, 0, 0, 32'h8000_0000, 0);
        run("R3", OP_XOR_REG, 64'hFF00, 64'hFF00, 1, 0, 0, 32'h8000_00FF, 0);
        run("R3", OP_ROTR, 64'h1, 64'h1, 1, 0, 0, 32'h0000_0041, 0);
        run("R3", OP_SUB_MEM, 64'h50, 64'h50, 1, 0, 0, 32'h7, 64'h20);
        run("R3", OP_XOR_MEM, 64'h5, 64'h5, 1, 0, 0, 32'h9, 64'hF0F0);
    endtask

    task automatic t_wrap;
        run("R4", OP_ADD_MEM, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0, 0, 64'h2);
        run("R4", OP_SUB_REG, 64'h0, 64'h1, 0, 0, 0, 0, 0);
        run("R4", OP_MUL_MEM, 64'h1_0000_0001, 0, 0, 0, 0, 0, 64'hFFFF_FFFF_0000_0003);
        run("R4", OP_MUL_REG, 64'hDEAD_BEEF_1234_5678, 64'h9876_5432_1FED_CBA9, 0, 0, 0, 0, 0);
    endtask

    task automatic t_mulh;
        run("R5", OP_MULHU_REG, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 0, 0, 0, 0, 0);
        run("R5", OP_MULHS_REG, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 0, 0, 0, 0, 0);
        run("R5", OP_MULHU_REG, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0001, 1, 0, 0, 32'h3, 0);
        run("R5", OP_MULHS_MEM, 64'h8000_0000_0000_0000, 0, 0, 0, 0, 0, 64'h8000_0000_0000_0000);
        run("R5", OP_MULHU_MEM, 64'h1234_5678_9ABC_DEF0, 0, 0, 0, 0, 0, 64'hF000_0000_0000_0000);
    endtask

    task automatic t_rot;
        run("R6", OP_ROTR, 64'h0000_0000_0000_00F1, 64'h104, 0, 0, 0, 0, 0);
        run("R6", OP_ROTL, 64'h8000_0000_0000_0001, 64'h3F, 0, 0, 0, 0, 0);
        run("R6", OP_ROTL, 64'hABCD, 64'h40, 0, 0, 0, 0, 0);
    endtask

    task automatic t_swap_neg;
        run("R7", OP_NEG, 64'h1, 0, 0, 0, 0, 0, 0);
        run("R7", OP_NEG, 64'h8000_0000_0000_0000, 0, 0, 0, 0, 0, 0);
        run("R7", OP_SWAP, 64'h1111, 64'h2222, 0, 0, 0, 0, 0);
        run("R7", OP_SWAP, 64'h3333, 64'h3333, 1, 0, 0, 0, 0);
    endtask

    task automatic t_rcp;
        run("R8", OP_MUL_RECIP, 64'h55, 0, 0, 0, 0, 32'h0, 0);
        run("R8", OP_MUL_RECIP, 64'h55, 0, 0, 0, 0, 32'h0001_0000, 0);
        run("R8", OP_MUL_RECIP, 64'h55, 0, 0, 0, 0, 32'h1, 0);
        run("R9", OP_MUL_RECIP, 64'h1, 0, 0, 0, 0, 32'h3, 0);
        run("R9", OP_MUL_RECIP, 64'hCAFE_F00D_1234_5678, 0, 0, 0, 0, 32'hFFFF_FFFF, 0);
        run("R9", OP_MUL_RECIP, 64'h7, 0, 0, 0, 0, 32'h8000_0001, 0);
    endtask

    task automatic t_rcp_ignore;
        logic [63:0] exp;
        int waited;
        exp = 64'h99 * ref_rcp(32'd10);
        @(negedge clk);
        start = 1'b1; op = OP_MUL_RECIP; dst_val = 64'h99; imm = 32'd10; same_reg = 0;
        @(negedge clk);
        op = OP_NEG; dst_val = 64'h5;
        @(negedge clk);
        start = 1'b0;
        check("R9", "ignored request no result", {63'd0, out_valid}, 64'd0);
        waited = 0;
        while (!out_valid && waited < 200) begin
            @(negedge clk);
            waited++;
        end
        check("R9", "result after ignored request", dst_out, exp);
        @(negedge clk);
        check("R9", "single result pulse", {63'd0, out_valid}, 64'd0);
    endtask

    task automatic t_branch;
        run("R10", OP_BRANCH, 64'h0, 0, 0, 0, 8'h00, 32'h0, 0);
        run("R11", OP_BRANCH, 64'hFFFF_FFFF_FFFF_FF00, 0, 0, 0, 8'h00, 32'h0, 0);
        run("R11", OP_BRANCH, 64'hFFFF_FFFF_FF80_0000, 0, 0, 0, 8'hF0, 32'h0, 0);
        run("R10", OP_BRANCH, 64'h1234, 0, 0, 0, 8'hF0, 32'hFFFF_FFFF, 0);
        run("R11", OP_BRANCH, 64'h0000_0000_8000_0000, 0, 0, 0, 8'hF0, 32'h7F00_0000, 0);
        run("R10", OP_BRANCH, 64'h0, 0, 0, 0, 8'h50, 32'h8000_1FFF, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; op = '0; dst_val = '0; src_val = '0;
        same_reg = 1'b0; dst_is_r5 = 1'b0; mod = '0; imm = '0; mem_val = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_add();
        t_same();
        t_wrap();
        t_mulh();
        t_rot();
        t_swap_neg();
        t_rcp();
        t_rcp_ignore();
        t_branch();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule